// File: doc/BRIEF.md
# Dual program-counter switch unit

This unit keeps two program counters, a primary and an auxiliary one, and presents the one currently in use as the fetch address. Two closely interlocked instruction streams can then take turns on one fetch path with very little overhead: the stream itself decides when to hand over by retiring one of three switch operations.

The three switch operations behave differently. The immediate switch hands over as soon as it retires. The deferred switch hands over once the following instruction has retired, and that instruction may be a jump. The branch-conditioned switch hands over only if the following instruction is a branch that redirects. The retire port carries each instruction's decoded flags and length. The active counter either steps past the retired instruction or loads the branch target. The inactive counter holds its value.

When a handover coincides with a redirecting branch, the branch target is loaded into the counter being switched to, and the counter being left gets the sequential return address. This is how the auxiliary counter is first initialised after the mode is turned on.

Top module: `dual_pc_switch`

## Requirements
- R1: Reset selects the primary counter (`aux_active_o` = 0), sets it to `PRI_RESET_PC` (default 0x1000), and drops any pending switch.
- R2: A retired non-switch, non-branch instruction advances the active counter by `insn_len_i`. A cycle without `retire_i` changes neither output.
- R3: A retired branch with `is_branch_i`=1 that is unconditional (`is_cond_i`=0) or taken (`taken_i`=1) makes `fetch_pc_o` equal `target_i` on the next cycle. A conditional branch that is not taken advances the counter by its length.
- R4: The inactive counter keeps its value while the other counter runs, and it is fetched unchanged when it becomes active again.
- R5: `sw_op_i`=1 (immediate) flips `aux_active_o` on its own retire. The counter being left holds the address after the switch operation.
- R6: `sw_op_i`=2 (deferred) does not flip on its own retire. It flips on the next retire. If that next instruction is a redirecting branch, the target goes to the newly active counter and the counter being left gets the sequential address.
- R7: `sw_op_i`=3 (branch-conditioned) followed by a conditional branch flips only if the branch is taken, with the target going to the newly active counter.
- R8: `sw_op_i`=3 followed by a non-branch instruction has no effect, and the pending state is discarded.
- R9: `sw_op_i`=3 followed by an unconditional branch flips the counters.
- R10: While `mode_en_i`=0 the switch operations have no effect. Any pending deferred or branch-conditioned switch is cleared, even in a cycle without a retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_en_i | input | 1 | Dual-counter mode enable |
| retire_i | input | 1 | One instruction retires this cycle |
| sw_op_i | input | 2 | 0 none, 1 immediate, 2 deferred, 3 branch-conditioned |
| is_branch_i | input | 1 | Retiring instruction is a branch |
| is_cond_i | input | 1 | Branch is conditional |
| taken_i | input | 1 | Conditional branch outcome |
| target_i | input | AW | Branch target |
| insn_len_i | input | LW | Length of the retiring instruction |
| fetch_pc_o | output | AW | Address from the active counter |
| aux_active_o | output | 1 | 1 when the auxiliary counter is active |

## Verification
A corrupted selector or a stray pending switch shows on the cycle after the next retire. `aux_active_o` flips when it should not, and `fetch_pc_o` jumps to the other counter's value. A wrong write into the inactive counter stays hidden until the next handover, so the test returns to each counter after it has been idle and compares the resumed address. Target steering during a handover is checked by reading both counters in turn after each switch that coincides with a jump.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [1:0] {
    SW_NONE  = 2'd0,
    SW_NOW   = 2'd1,
    SW_DEFER = 2'd2,
    SW_IFBR  = 2'd3
  } sw_op_e;
endpackage

// File: rtl/dpc_next_pc.sv
module dpc_next_pc #(
  parameter int AW = 32,
  parameter int LW = 3
) (
  input  logic [AW-1:0] cur_pc_i,
  input  logic [LW-1:0] len_i,
  input  logic [1:0]    sw_op_i,
  input  logic          is_branch_i,
  input  logic          is_cond_i,
  input  logic          taken_i,
  output logic [AW-1:0] seq_pc_o,
  output logic          redirect_o
);
  import dpc_pkg::*;
  localparam int PadW = AW - LW;

  assign seq_pc_o   = cur_pc_i + {{PadW{1'b0}}, len_i};
  // switch operations never redirect; branch flags are ignored for them
  assign redirect_o = (sw_op_e'(sw_op_i) == SW_NONE) && is_branch_i && (taken_i || !is_cond_i);
endmodule

// File: rtl/dpc_switch_ctrl.sv
module dpc_switch_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_en_i,
  input  logic       retire_i,
  input  logic [1:0] sw_op_i,
  input  logic       redirect_i,
  output logic       active_o,
  output logic       toggle_o,
  output logic       pend_after_o,
  output logic       pend_br_o
);
  import dpc_pkg::*;
  sw_op_e op;
  logic   active_q, pend_after_q, pend_br_q;
  logic   fire;

  assign op       = sw_op_e'(sw_op_i);
  assign fire     = pend_after_q | (pend_br_q & redirect_i);
  assign toggle_o = retire_i & mode_en_i & (fire ^ (op == SW_NOW));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q     <= 1'b0;
      pend_after_q <= 1'b0;
      pend_br_q    <= 1'b0;
    end else begin
      active_q <= active_q ^ toggle_o;
      if (!mode_en_i) begin
        pend_after_q <= 1'b0;
        pend_br_q    <= 1'b0;
      end else if (retire_i) begin
        pend_after_q <= (op == SW_DEFER);
        pend_br_q    <= (op == SW_IFBR);
      end
    end
  end

  assign active_o     = active_q;
  assign pend_after_o = pend_after_q;
  assign pend_br_o    = pend_br_q;
endmodule

// File: rtl/dpc_pc_bank.sv
module dpc_pc_bank #(
  parameter int          AW     = 32,
  parameter int          NPC    = 2,
  parameter logic [AW-1:0] RST0 = '0,
  parameter logic [AW-1:0] RST1 = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NPC-1:0]      wr_en_i,
  input  logic [NPC-1:0][AW-1:0] wr_data_i,
  output logic [NPC-1:0][AW-1:0] pc_o
);
  for (genvar g = 0; g < NPC; g++) begin : g_pc
    localparam logic [AW-1:0] RstVal = (g == 0) ? RST0 : RST1;
    logic [AW-1:0] pc_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         pc_q <= RstVal;
      else if (wr_en_i[g]) pc_q <= wr_data_i[g];
    end
    assign pc_o[g] = pc_q;
  end
endmodule

// File: rtl/dual_pc_switch.sv
module dual_pc_switch #(
  parameter int            AW          = 32,
  parameter int            LW          = 3,
  parameter logic [AW-1:0] PRI_RESET_PC = 32'h0000_1000,
  parameter logic [AW-1:0] AUX_RESET_PC = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_en_i,
  input  logic          retire_i,
  input  logic [1:0]    sw_op_i,
  input  logic          is_branch_i,
  input  logic          is_cond_i,
  input  logic          taken_i,
  input  logic [AW-1:0] target_i,
  input  logic [LW-1:0] insn_len_i,
  output logic [AW-1:0] fetch_pc_o,
  output logic          aux_active_o
);
  localparam int NPC = 2;

  logic                   active, toggle, redirect, pend_after, pend_br;
  logic [AW-1:0]          seq_pc;
  logic [NPC-1:0]         wr_en;
  logic [NPC-1:0][AW-1:0] wr_data, pc;

  dpc_switch_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_en_i   (mode_en_i),
    .retire_i    (retire_i),
    .sw_op_i     (sw_op_i),
    .redirect_i  (redirect),
    .active_o    (active),
    .toggle_o    (toggle),
    .pend_after_o(pend_after),
    .pend_br_o   (pend_br)
  );

  dpc_next_pc #(.AW(AW), .LW(LW)) u_next (
    .cur_pc_i   (fetch_pc_o),
    .len_i      (insn_len_i),
    .sw_op_i    (sw_op_i),
    .is_branch_i(is_branch_i),
    .is_cond_i  (is_cond_i),
    .taken_i    (taken_i),
    .seq_pc_o   (seq_pc),
    .redirect_o (redirect)
  );

  // current counter: return address on handover-with-jump, else next address;
  // other counter: written only when a handover carries a jump target
  for (genvar g = 0; g < NPC; g++) begin : g_wr
    logic is_cur;
    assign is_cur = (active == g[0]);
    always_comb begin
      wr_en[g]   = 1'b0;
      wr_data[g] = seq_pc;
      if (retire_i) begin
        if (is_cur) begin
          wr_en[g]   = 1'b1;
          wr_data[g] = (redirect && !toggle) ? target_i : seq_pc;
        end else if (toggle && redirect) begin
          wr_en[g]   = 1'b1;
          wr_data[g] = target_i;
        end
      end
    end
  end

  dpc_pc_bank #(.AW(AW), .NPC(NPC), .RST0(PRI_RESET_PC), .RST1(AUX_RESET_PC)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_data_i(wr_data),
    .pc_o     (pc)
  );

  assign fetch_pc_o   = pc[active];
  assign aux_active_o = active;
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int AW = 32,
  parameter int LW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mode_en_i,
  input logic          retire_i,
  input logic [1:0]    sw_op_i,
  input logic          is_branch_i,
  input logic          is_cond_i,
  input logic          taken_i,
  input logic [AW-1:0] target_i,
  input logic [LW-1:0] insn_len_i,
  input logic [AW-1:0] fetch_pc_o,
  input logic          aux_active_o,
  input logic          pend_after,
  input logic          pend_br
);
  localparam int PadW = AW - LW;

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retire_i |=> $stable(fetch_pc_o) && $stable(aux_active_o));

  assert_step_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i && sw_op_i == 2'd0 && !is_branch_i && !pend_after
    |=> fetch_pc_o == $past(fetch_pc_o + {{PadW{1'b0}}, insn_len_i}));

  assert_taken_target_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i && sw_op_i == 2'd0 && is_branch_i && (taken_i || !is_cond_i)
    |=> fetch_pc_o == $past(target_i));

  assert_now_flips_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i && mode_en_i && sw_op_i == 2'd1 && !pend_after
    |=> aux_active_o != $past(aux_active_o));

  assert_defer_waits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i && mode_en_i && sw_op_i == 2'd2 && !pend_after
    |=> $stable(aux_active_o));

  assert_ifbr_nonbranch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i && sw_op_i == 2'd0 && !is_branch_i && pend_br && !pend_after
    |=> $stable(aux_active_o) && !pend_br);

  assert_disabled_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_en_i |=> $stable(aux_active_o) && !pend_after && !pend_br);
endmodule

bind dual_pc_switch dpc_checker #(.AW(AW), .LW(LW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_en_i   (mode_en_i),
  .retire_i    (retire_i),
  .sw_op_i     (sw_op_i),
  .is_branch_i (is_branch_i),
  .is_cond_i   (is_cond_i),
  .taken_i     (taken_i),
  .target_i    (target_i),
  .insn_len_i  (insn_len_i),
  .fetch_pc_o  (fetch_pc_o),
  .aux_active_o(aux_active_o),
  .pend_after  (pend_after),
  .pend_br     (pend_br)
);

// File: tb/test_dual_pc_switch.sv
module test_dual_pc_switch;
  localparam int AW = 32;
  localparam int LW = 3;

  typedef struct packed {
    logic [1:0]    op;
    logic          br;
    logic          cnd;
    logic          tk;
    logic [AW-1:0] tgt;
    logic [LW-1:0] len;
    logic [AW-1:0] exp_pc;
    logic          exp_aux;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 32'h0,    3'd2, 32'h1002, 1'b0, 8'd2},  // R2
    '{2'd0, 1'b0, 1'b0, 1'b0, 32'h0,    3'd4, 32'h1006, 1'b0, 8'd2},
    '{2'd0, 1'b1, 1'b1, 1'b1, 32'h2000, 3'd2, 32'h2000, 1'b0, 8'd3},  // R3 taken
    '{2'd0, 1'b1, 1'b1, 1'b0, 32'h3000, 3'd2, 32'h2002, 1'b0, 8'd3},  // R3 not taken
    '{2'd0, 1'b1, 1'b0, 1'b0, 32'h2100, 3'd2, 32'h2100, 1'b0, 8'd3},  // R3 uncond
    '{2'd2, 1'b0, 1'b0, 1'b0, 32'h0,    3'd2, 32'h2102, 1'b0, 8'd6},  // R6 no flip yet
    '{2'd0, 1'b1, 1'b0, 1'b0, 32'h8000, 3'd4, 32'h8000, 1'b1, 8'd6},  // R6 jump inits aux
    '{2'd0, 1'b0, 1'b0, 1'b0, 32'h0,    3'd2, 32'h8002, 1'b1, 8'd2},
    '{2'd1, 1'b0, 1'b0, 1'b0, 32'h0,    3'd2, 32'h2106, 1'b0, 8'd5},  // R5, R4 primary held
    '{2'd3, 1'b0, 1'b0, 1'b0, 32'h0,    3'd2, 32'h2108, 1'b0, 8'd7},
    '{2'd0, 1'b1, 1'b1, 1'b0, 32'h9000, 3'd2, 32'h210A, 1'b0, 8'd7},  // R7 not taken
    '{2'd3, 1'b0, 1'b0, 1'b0, 32'h0,    3'd2, 32'h210C, 1'b0, 8'd7},
    '{2'd0, 1'b1, 1'b1, 1'b1, 32'h3000, 3'd2, 32'h3000, 1'b1, 8'd7},  // R7 taken
    '{2'd3, 1'b0, 1'b0, 1'b0, 32'h0,    3'd2, 32'h3002, 1'b1, 8'd8},
    '{2'd0, 1'b0, 1'b0, 1'b0, 32'h0,    3'd4, 32'h3006, 1'b1, 8'd8},  // R8 no effect
    '{2'd0, 1'b0, 1'b0, 1'b0, 32'h0,    3'd2, 32'h3008, 1'b1, 8'd8},  // R8 pending gone
    '{2'd3, 1'b0, 1'b0, 1'b0, 32'h0,    3'd2, 32'h300A, 1'b1, 8'd9},
    '{2'd0, 1'b1, 1'b0, 1'b0, 32'h4000, 3'd2, 32'h4000, 1'b0, 8'd9},  // R9
    '{2'd1, 1'b0, 1'b0, 1'b0, 32'h0,    3'd2, 32'h300C, 1'b1, 8'd4},  // R4 aux held
    '{2'd1, 1'b0, 1'b0, 1'b0, 32'h0,    3'd4, 32'h4002, 1'b0, 8'd4}   // R4 primary held
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_en = 1'b1;
  logic          retire = 1'b0;
  logic [1:0]    sw_op = '0;
  logic          is_branch = 1'b0, is_cond = 1'b0, taken = 1'b0;
  logic [AW-1:0] target = '0;
  logic [LW-1:0] len = '0;
  logic [AW-1:0] fetch_pc;
  logic          aux_active;
  int            n_checks = 0, n_errors = 0;

  always #10 clk = ~clk;

  dual_pc_switch #(.AW(AW), .LW(LW)) i_dual_pc_switch (
    .clk_i(clk), .rst_ni(rst_n), .mode_en_i(mode_en), .retire_i(retire),
    .sw_op_i(sw_op), .is_branch_i(is_branch), .is_cond_i(is_cond), .taken_i(taken),
    .target_i(target), .insn_len_i(len), .fetch_pc_o(fetch_pc), .aux_active_o(aux_active)
  );

  task automatic check(input string tag, input logic [AW-1:0] exp_pc, input logic exp_aux);
    n_checks++;
    if (fetch_pc !== exp_pc || aux_active !== exp_aux) begin
      n_errors++;
      $display("FAIL %s: pc=%h aux=%b expected pc=%h aux=%b", tag, fetch_pc, aux_active,
               exp_pc, exp_aux);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic b, input logic c, input logic t,
                      input logic [AW-1:0] tg, input logic [LW-1:0] l);
    @(negedge clk);
    sw_op = op; is_branch = b; is_cond = c; taken = t; target = tg; len = l; retire = 1'b1;
    @(negedge clk);
    retire = 1'b0; sw_op = '0; is_branch = 1'b0; is_cond = 1'b0; taken = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: pc=%h aux=%b expected pc=done aux=done", fetch_pc, aux_active);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset", 32'h1000, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 32'h1000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].op, VECS[i].br, VECS[i].cnd, VECS[i].tk, VECS[i].tgt, VECS[i].len);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].exp_pc, VECS[i].exp_aux);
    end

    // R2: idle cycles hold
    repeat (3) @(negedge clk);
    check("R2 idle hold", 32'h4002, 1'b0);

    // R10: switch operations ignored while disabled
    mode_en = 1'b0;
    step(2'd1, 1'b0, 1'b0, 1'b0, '0, 3'd2);
    check("R10 immediate ignored", 32'h4004, 1'b0);
    step(2'd2, 1'b0, 1'b0, 1'b0, '0, 3'd2);
    step(2'd0, 1'b1, 1'b0, 1'b0, 32'h5000, 3'd2);
    check("R10 deferred ignored", 32'h5000, 1'b0);
    mode_en = 1'b1;
    step(2'd2, 1'b0, 1'b0, 1'b0, '0, 3'd2);
    mode_en = 1'b0;
    @(negedge clk);
    mode_en = 1'b1;
    step(2'd0, 1'b0, 1'b0, 1'b0, '0, 3'd2);
    check("R10 pending cleared by disable", 32'h5004, 1'b0);

    // R1: reset drops pending switch and restores counters
    step(2'd2, 1'b0, 1'b0, 1'b0, '0, 3'd2);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", 32'h1000, 1'b0);
    rst_n = 1'b1;
    step(2'd0, 1'b0, 1'b0, 1'b0, '0, 3'd4);
    check("R1 pending dropped", 32'h1004, 1'b0);

    // R6 + R4: deferred with non-branch follower switches to reset aux value
    step(2'd2, 1'b0, 1'b0, 1'b0, '0, 3'd2);
    step(2'd0, 1'b0, 1'b0, 1'b0, '0, 3'd2);
    check("R6 deferred non-branch follower", 32'h0000, 1'b1);
    step(2'd1, 1'b0, 1'b0, 1'b0, '0, 3'd2);
    check("R4 primary return address", 32'h1008, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule